// File: doc/BRIEF.md
# Debug Control and Status Registers

This block holds the control and status registers of an on-chip debug unit for a small 8-bit CPU. When the CPU decodes a breakpoint instruction it signals a single-cycle strobe. If breakpoints are enabled, a control bit decides the outcome. One setting puts the unit into debug mode. The other setting leaves debug mode alone and asserts a hold output, which keeps the CPU looping on the breakpoint instruction.

The control register can also request a system reset. The request stays asserted until the reset sequence reports completion. The debug logic sits outside that reset and is cleared only by its own `rst_ni`. The status register reports three things: whether the CPU is idle, the CPU's halt state and a read-protect flag. The idle bit covers two cases, debug mode and any breakpoint acted on since the last control write.

The register port has one address bit: 0 selects control and 1 selects status. Writes are taken on the rising clock edge. Read data is combinational from the address.

Top module: `dbg_ctl_regs`

## Requirements
- R1: A breakpoint strobe while the enable bit (control bit 6) is 0 changes neither `dbg_mode_o`, `brk_loop_o` nor the idle status bit.
- R2: A breakpoint strobe with enable at 1 and the loop bit (control bit 4) at 0 sets `dbg_mode_o` on the following cycle.
- R3: A breakpoint strobe with enable at 1 and the loop bit at 1 sets `brk_loop_o` on the following cycle and leaves `dbg_mode_o` unchanged.
- R4: `brk_loop_o` stays at 1 until a control write either sets bit 7 to 1 or clears bit 4. A breakpoint that sets the hold in the same cycle wins over the release.
- R5: Reading the control address returns debug mode in bit 7, enable in bit 6, loop in bit 4 and the reset request in bit 0. Bits 5 and 3:1 always read 0, whatever was written to them.
- R6: A control write with bit 0 at 1 raises `sys_rst_req_o` on the next cycle. The request holds until a `sys_rst_done_i` pulse clears it. Writing 0 to bit 0 has no effect. A set in the same cycle as a done pulse wins.
- R7: Status bit 7 reads `dbg_mode_o` OR a sticky breakpoint flag. The flag is set by an enabled breakpoint and cleared by any control write. A breakpoint in the same cycle as that write leaves the flag set.
- R8: Status bit 6 follows `halt_mode_i` and bit 5 follows `rd_protect_i`. Bits 4:0 read 0. Writes to the status address change nothing.
- R9: After `rst_ni` every control bit, the sticky flag and all outputs are 0.
- R10: Control bit 7 is written directly by a control write. An enabled non-looping breakpoint in the same cycle forces it to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the debug logic |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = control, 1 = status |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for the addressed register |
| brk_decode_i | input | 1 | CPU decoded a breakpoint instruction (one cycle) |
| halt_mode_i | input | 1 | CPU is in halt mode |
| rd_protect_i | input | 1 | Read-protect enable flag |
| sys_rst_done_i | input | 1 | System reset sequence finished (one-cycle pulse) |
| dbg_mode_o | output | 1 | Debug mode active |
| brk_loop_o | output | 1 | Hold CPU looping on the breakpoint instruction |
| sys_rst_req_o | output | 1 | System reset request |

## Verification
The bench builds the block with its default `DATA_W` of 8, so every control and status bit sits where the requirements place it. At that width a random write pattern covers the reserved positions as well as the live ones. It also reaches every collision of a control write with a breakpoint strobe and with a reset-done pulse. Directed sequences add the ordered cases: releasing the loop hold, the sticky idle flag surviving a write in the same cycle, and a zero write to the reset bit.

// File: rtl/dbg_regs_pkg.sv
package dbg_regs_pkg;
  localparam int unsigned CTL_DBG_BIT   = 7;
  localparam int unsigned CTL_EN_BIT    = 6;
  localparam int unsigned CTL_LOOP_BIT  = 4;
  localparam int unsigned CTL_RST_BIT   = 0;
  localparam int unsigned STAT_IDLE_BIT = 7;
  localparam int unsigned STAT_HALT_BIT = 6;
  localparam int unsigned STAT_RDP_BIT  = 5;

  typedef enum logic {
    SEL_CTL  = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic dbg_mode;
    logic brk_en;
    logic loop_sel;
    logic rst_req;
  } ctl_state_t;
endpackage

// File: rtl/dbg_ctl_bank.sv
module dbg_ctl_bank (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic                    wr_dbg_i,
  input  logic                    wr_en_i,
  input  logic                    wr_loop_i,
  input  logic                    wr_rst_i,
  input  logic                    brk_i,
  input  logic                    rst_done_i,
  output dbg_regs_pkg::ctl_state_t state_o,
  output logic                    hold_o,
  output logic                    brk_act_o
);
  import dbg_regs_pkg::*;

  ctl_state_t st_q, st_d;
  logic hold_q, hold_d;
  logic brk_act, enter_dbg, enter_loop, hold_rel;

  // breakpoint decisions use the register state before this edge
  assign brk_act    = brk_i && st_q.brk_en;
  assign enter_dbg  = brk_act && !st_q.loop_sel;
  assign enter_loop = brk_act && st_q.loop_sel;
  assign hold_rel   = wr_i && (wr_dbg_i || !wr_loop_i);

  always_comb begin
    st_d = st_q;
    if (wr_i) begin
      st_d.dbg_mode = wr_dbg_i;
      st_d.brk_en   = wr_en_i;
      st_d.loop_sel = wr_loop_i;
    end
    if (enter_dbg) st_d.dbg_mode = 1'b1;
    if (rst_done_i) st_d.rst_req = 1'b0;
    if (wr_i && wr_rst_i) st_d.rst_req = 1'b1;

    hold_d = hold_q;
    if (hold_rel)   hold_d = 1'b0;
    if (enter_loop) hold_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      hold_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      hold_q <= hold_d;
    end
  end

  assign state_o   = st_q;
  assign hold_o    = hold_q;
  assign brk_act_o = brk_act;
endmodule

// File: rtl/dbg_idle_track.sv
module dbg_idle_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctl_wr_i,
  input  logic brk_act_i,
  input  logic dbg_mode_i,
  output logic idle_o
);
  logic seen_q;

  // set beats clear when both land in one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        seen_q <= 1'b0;
    else if (brk_act_i) seen_q <= 1'b1;
    else if (ctl_wr_i)  seen_q <= 1'b0;
  end

  assign idle_o = seen_q || dbg_mode_i;
endmodule

// File: rtl/dbg_rd_mux.sv
module dbg_rd_mux #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                     sel_i,
  input  dbg_regs_pkg::ctl_state_t ctl_i,
  input  logic                     idle_i,
  input  logic                     halt_i,
  input  logic                     rdp_i,
  output logic [DATA_W-1:0]        rdata_o
);
  import dbg_regs_pkg::*;

  logic [DATA_W-1:0] ctl_word, stat_word;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == CTL_DBG_BIT)       begin : g_c7 assign ctl_word[b] = ctl_i.dbg_mode; end
    else if (b == CTL_EN_BIT)   begin : g_c6 assign ctl_word[b] = ctl_i.brk_en;   end
    else if (b == CTL_LOOP_BIT) begin : g_c4 assign ctl_word[b] = ctl_i.loop_sel; end
    else if (b == CTL_RST_BIT)  begin : g_c0 assign ctl_word[b] = ctl_i.rst_req;  end
    else                        begin : g_cz assign ctl_word[b] = 1'b0;           end

    if (b == STAT_IDLE_BIT)      begin : g_s7 assign stat_word[b] = idle_i; end
    else if (b == STAT_HALT_BIT) begin : g_s6 assign stat_word[b] = halt_i; end
    else if (b == STAT_RDP_BIT)  begin : g_s5 assign stat_word[b] = rdp_i;  end
    else                         begin : g_sz assign stat_word[b] = 1'b0;   end
  end

  assign rdata_o = (sel_i == SEL_STAT) ? stat_word : ctl_word;
endmodule

// File: rtl/dbg_ctl_regs.sv
module dbg_ctl_regs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              brk_decode_i,
  input  logic              halt_mode_i,
  input  logic              rd_protect_i,
  input  logic              sys_rst_done_i,
  output logic              dbg_mode_o,
  output logic              brk_loop_o,
  output logic              sys_rst_req_o
);
  import dbg_regs_pkg::*;

  ctl_state_t ctl_st;
  logic ctl_wr, brk_act, idle, brk_en, loop_sel;

  assign ctl_wr = reg_we_i && (reg_addr_i == SEL_CTL);

  dbg_ctl_bank u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (ctl_wr),
    .wr_dbg_i   (reg_wdata_i[CTL_DBG_BIT]),
    .wr_en_i    (reg_wdata_i[CTL_EN_BIT]),
    .wr_loop_i  (reg_wdata_i[CTL_LOOP_BIT]),
    .wr_rst_i   (reg_wdata_i[CTL_RST_BIT]),
    .brk_i      (brk_decode_i),
    .rst_done_i (sys_rst_done_i),
    .state_o    (ctl_st),
    .hold_o     (brk_loop_o),
    .brk_act_o  (brk_act)
  );

  dbg_idle_track u_idle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_wr_i   (ctl_wr),
    .brk_act_i  (brk_act),
    .dbg_mode_i (ctl_st.dbg_mode),
    .idle_o     (idle)
  );

  dbg_rd_mux #(.DATA_W(DATA_W)) u_rd (
    .sel_i   (reg_addr_i),
    .ctl_i   (ctl_st),
    .idle_i  (idle),
    .halt_i  (halt_mode_i),
    .rdp_i   (rd_protect_i),
    .rdata_o (reg_rdata_o)
  );

  assign dbg_mode_o    = ctl_st.dbg_mode;
  assign sys_rst_req_o = ctl_st.rst_req;
  assign brk_en        = ctl_st.brk_en;
  assign loop_sel      = ctl_st.loop_sel;
endmodule

// File: rtl/dbg_ctl_regs_chk.sv
module dbg_ctl_regs_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic              reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              brk_decode_i,
  input logic              sys_rst_done_i,
  input logic              dbg_mode_o,
  input logic              brk_loop_o,
  input logic              sys_rst_req_o,
  input logic              brk_en,
  input logic              loop_sel
);
  logic wr_ctl;
  assign wr_ctl = reg_we_i && !reg_addr_i;

  // R1
  brk_off_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_decode_i && !brk_en && !wr_ctl) |=> ($stable(dbg_mode_o) && $stable(brk_loop_o)));

  // R2
  brk_enters_dbg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_decode_i && brk_en && !loop_sel) |=> dbg_mode_o);

  // R3
  brk_enters_loop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_decode_i && brk_en && loop_sel) |=> brk_loop_o);

  // R3
  loop_keeps_dbg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_decode_i && brk_en && loop_sel && !wr_ctl) |=> $stable(dbg_mode_o));

  // R6
  rst_req_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_req_o && !sys_rst_done_i) |=> sys_rst_req_o);

  // R6
  rst_req_no_spur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_req_o && !(wr_ctl && reg_wdata_i[0])) |=> !sys_rst_req_o);

  // R5
  ctl_reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_addr_i |-> (reg_rdata_o[5] == 1'b0 && reg_rdata_o[3:1] == 3'b000));

  // R8
  stat_reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_i |-> (reg_rdata_o[4:0] == 5'b00000));

  // R7
  idle_in_dbg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i && dbg_mode_o) |-> reg_rdata_o[7]);
endmodule

bind dbg_ctl_regs dbg_ctl_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .reg_we_i       (reg_we_i),
  .reg_addr_i     (reg_addr_i),
  .reg_wdata_i    (reg_wdata_i),
  .reg_rdata_o    (reg_rdata_o),
  .brk_decode_i   (brk_decode_i),
  .sys_rst_done_i (sys_rst_done_i),
  .dbg_mode_o     (dbg_mode_o),
  .brk_loop_o     (brk_loop_o),
  .sys_rst_req_o  (sys_rst_req_o),
  .brk_en         (brk_en),
  .loop_sel       (loop_sel)
);

// File: tb/dbg_ctl_regs_bench.sv
module dbg_ctl_regs_bench;
  localparam int CLK_P = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0, addr = 1'b0, brk = 1'b0, halt = 1'b0, rdp = 1'b0, done = 1'b0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] rd;
  logic dbg, hold, rreq;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // model state
  logic m_dbg = 0, m_en = 0, m_loop = 0, m_rst = 0, m_seen = 0, m_hold = 0;

  always #(CLK_P/2) clk = ~clk;

  dbg_ctl_regs #(.DATA_W(DW)) u_dbg_ctl_regs (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wd), .reg_rdata_o(rd), .brk_decode_i(brk),
    .halt_mode_i(halt), .rd_protect_i(rdp), .sys_rst_done_i(done),
    .dbg_mode_o(dbg), .brk_loop_o(hold), .sys_rst_req_o(rreq)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] exp_ctl();
    return {m_dbg, m_en, 1'b0, m_loop, 3'b000, m_rst};
  endfunction

  function automatic logic [DW-1:0] exp_stat(input logic h, input logic p);
    return {m_dbg | m_seen, h, p, 5'b00000};
  endfunction

  // one cycle: drive at negedge, check read, clock, update model, check outputs
  task automatic step(input logic w, input logic a, input logic [DW-1:0] d,
                      input logic b, input logic dn);
    logic wr, act, n_dbg;
    we = w; addr = a; wd = d; brk = b; done = dn;
    #1;
    if (a) chk("R8 status read", rd, exp_stat(halt, rdp));
    else   chk("R5 control read", rd, exp_ctl());
    wr  = w && !a;
    act = b && m_en;
    @(posedge clk);
    n_dbg  = (wr ? d[7] : m_dbg) | (act && !m_loop);
    m_hold = (act && m_loop) | (m_hold & !(wr && (d[7] || !d[4])));
    m_rst  = (wr && d[0]) | (m_rst & !dn);
    m_seen = act | (m_seen & !wr);
    if (wr) begin m_en = d[6]; m_loop = d[4]; end
    m_dbg  = n_dbg;
    @(negedge clk);
    we = 0; brk = 0; done = 0;
    chk("R10 dbg_mode_o", {7'b0, dbg}, {7'b0, m_dbg});
    chk("R4 brk_loop_o", {7'b0, hold}, {7'b0, m_hold});
    chk("R6 sys_rst_req_o", {7'b0, rreq}, {7'b0, m_rst});
  endtask

  task automatic peek(input logic a, output logic [DW-1:0] v);
    addr = a; #1; v = rd;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'd1234));
    #(CLK_P * 3);
    @(negedge clk); rst_n = 1'b1;
    // R9 reset state
    chk("R9 outputs after reset", {5'b0, dbg, hold, rreq}, 8'h00);
    peek(1'b0, v); chk("R9 control after reset", v, 8'h00);
    peek(1'b1, v); chk("R9 idle after reset", {7'b0, v[7]}, 8'h00);

    // R1 breakpoint ignored when disabled
    step(0, 0, 8'h00, 1, 0);
    chk("R1 dbg stays 0", {7'b0, dbg}, 8'h00);
    chk("R1 hold stays 0", {7'b0, hold}, 8'h00);
    peek(1'b1, v); chk("R1 idle stays 0", {7'b0, v[7]}, 8'h00);

    // R2 enter debug mode
    step(1, 0, 8'h40, 0, 0);
    step(0, 0, 8'h00, 1, 0);
    chk("R2 dbg set by breakpoint", {7'b0, dbg}, 8'h01);

    // R3 loop on breakpoint
    step(1, 0, 8'h50, 0, 0);
    step(0, 0, 8'h00, 1, 0);
    chk("R3 hold set", {7'b0, hold}, 8'h01);
    chk("R3 dbg unchanged", {7'b0, dbg}, 8'h00);

    // R7 sticky idle, write with breakpoint in same cycle keeps it
    peek(1'b1, v); chk("R7 idle after loop breakpoint", {7'b0, v[7]}, 8'h01);
    step(1, 0, 8'h50, 1, 0);
    peek(1'b1, v); chk("R7 idle set wins over write", {7'b0, v[7]}, 8'h01);
    step(1, 0, 8'h50, 0, 0);
    peek(1'b1, v); chk("R7 idle cleared by write", {7'b0, v[7]}, 8'h00);

    // R4 hold release
    chk("R4 hold kept while loop bit stays", {7'b0, hold}, 8'h01);
    step(1, 0, 8'h40, 0, 0);
    chk("R4 hold released by loop clear", {7'b0, hold}, 8'h00);
    step(1, 0, 8'h50, 0, 0);
    step(0, 0, 8'h00, 1, 0);
    step(1, 0, 8'hD0, 0, 0);
    chk("R4 hold released by dbg write", {7'b0, hold}, 8'h00);

    // R5 reserved bits read 0
    step(1, 0, 8'hFF, 0, 0);
    peek(1'b0, v); chk("R5 readback of all-ones write", v, 8'hD1);

    // R6 reset request
    step(1, 0, 8'h40, 0, 0);
    chk("R6 zero write keeps request", {7'b0, rreq}, 8'h01);
    step(0, 0, 8'h00, 0, 1);
    chk("R6 done clears request", {7'b0, rreq}, 8'h00);
    step(1, 0, 8'h40, 0, 0);
    chk("R6 zero write does not set", {7'b0, rreq}, 8'h00);
    step(1, 0, 8'h41, 0, 1);
    chk("R6 set wins over done", {7'b0, rreq}, 8'h01);
    step(0, 0, 8'h00, 0, 1);

    // R8 status write ignored, halt/rdp mirrored
    peek(1'b0, v);
    step(1, 1, 8'hFF, 0, 0);
    begin
      logic [DW-1:0] v2;
      peek(1'b0, v2); chk("R8 status write ignored", v2, v);
    end
    halt = 1; rdp = 0; peek(1'b1, v); chk("R8 halt bit", v[6:0], 7'h40);
    halt = 0; rdp = 1; peek(1'b1, v); chk("R8 read-protect bit", v[6:0], 7'h20);

    // R10 write sets dbg directly; breakpoint wins over write of 0
    step(1, 0, 8'hC0, 0, 0);
    chk("R10 dbg written", {7'b0, dbg}, 8'h01);
    step(1, 0, 8'h40, 1, 0);
    chk("R10 breakpoint wins over write", {7'b0, dbg}, 8'h01);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic w, a, b, dn;
      w  = ($urandom % 3) == 0;
      a  = ($urandom % 4) == 0;
      b  = ($urandom % 4) == 0;
      dn = ($urandom % 6) == 0;
      halt = $urandom % 2;
      rdp  = $urandom % 2;
      step(w, a, DW'($urandom), b, dn);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule